// File: doc/BRIEF.md
# Delayed Read Transaction Tracker

This block follows a single delayed read from the moment a bus target accepts it until the data has been handed back or thrown away. When the target side raises its request qualifier while the tracker is idle, the tracker stores the address, byte enables, write flag, bus command and burst-allowed flag. It keeps them on its outputs so that the target can tell whether a later retried read is the same transaction. It sends a one-cycle request strobe to the back-end master and shows the request as pending.

The master answers with a one-cycle completion strobe and a status bit, where 0 means a normal completion and 1 means the read was terminated with an error. The tracker then raises a completion-pending flag for the target side and keeps the status with it. The target side reports with a done pulse once the last data phase of the matching read has finished. That pulse returns the tracker to idle. While the target is still moving data it holds an in-progress input high, and this freezes a discard timer. If the completion is left uncollected for 2^16 counted cycles, the tracker pulses a flush output for one cycle and drops the transaction. Both sides share one clock.

Top module: `dlyrd_tracker`

## Requirements
- R1: While the active-high asynchronous reset is asserted, every output is 0: stored fields, both pending flags, the status, the request strobe and the flush pulse.
- R2: When the tracker is idle at a rising edge with the request qualifier high, the address, byte enables, write flag, command and burst flag appear on the stored outputs after that edge. The request strobe is high for exactly that one following cycle.
- R3: A request qualifier seen while a request or completion is pending is ignored. The stored fields keep their values and no request strobe is produced.
- R4: The request-pending output is high from the cycle after acceptance until the edge at which the master completion strobe is sampled.
- R5: A completion strobe sampled while a request is pending raises completion-pending and stores the status bit (1 = error) on the status output. A completion strobe at any other time is ignored. The request-pending and completion-pending outputs are never high together.
- R6: A done pulse sampled while completion-pending is high returns the tracker to idle on the next cycle and clears the status. A done pulse in any other state has no effect.
- R7: Each edge with completion-pending high and in-progress high leaves the discard timer unchanged, which delays the flush by one cycle.
- R8: A flush occurs when completion-pending has been high for 2^TMR_W edges that are neither in-progress nor done. The flush output is high for exactly one cycle, and completion-pending falls in the same cycle.
- R9: The discard timer restarts from zero on every entry into completion-pending.
- R10: If done arrives at the very edge at which the timer would expire, done wins: no flush is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Asynchronous reset, active high |
| tgt_req_i | input | 1 | Request qualifier from the target side |
| tgt_addr_i | input | 32 | Request address |
| tgt_be_i | input | 4 | Request byte enables |
| tgt_wr_i | input | 1 | Write flag (1 = write) |
| tgt_cmd_i | input | 4 | Bus command |
| tgt_burst_i | input | 1 | Burst / prefetch allowed |
| tgt_done_i | input | 1 | Last data phase of the matching read finished |
| tgt_busy_i | input | 1 | Completion transfer in progress; holds the timer |
| mst_cmp_stb_i | input | 1 | One-cycle completion strobe from the master |
| mst_cmp_err_i | input | 1 | Completion status, 1 = error terminated |
| mst_req_stb_o | output | 1 | One-cycle request-valid strobe to the master |
| st_addr_o | output | 32 | Stored address |
| st_be_o | output | 4 | Stored byte enables |
| st_wr_o | output | 1 | Stored write flag |
| st_cmd_o | output | 4 | Stored bus command |
| st_burst_o | output | 1 | Stored burst flag |
| req_pend_o | output | 1 | Request waiting on the master side |
| cmp_pend_o | output | 1 | Completion ready for the target side |
| cmp_err_o | output | 1 | Stored completion status |
| cmp_flush_o | output | 1 | One-cycle discard pulse on timer expiry |

## Verification
The bench runs a full transaction in which done arrives early. This separates a clean return to idle from a timeout. It then sends request, completion and done pulses in states where they must be ignored, so that a decoder that reacts in every state shows up as wrong stored fields or a spurious strobe. Two long waits go against the 2^16 limit. In the first, a partial wait comes before the entry, and an in-progress hold falls in the middle of the wait. This tells apart a timer that restarts on entry and freezes under the hold from one that keeps counting. In the second, done lands on the exact expiry edge to show which of the two has priority.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CMP  = 2'd2
  } dly_state_e;

  function automatic logic can_accept(input dly_state_e st, input logic req);
    return (st == ST_IDLE) && req;
  endfunction

  function automatic logic can_finish(input dly_state_e st, input logic stb);
    return (st == ST_REQ) && stb;
  endfunction
endpackage

// File: rtl/dlyrd_capture.sv
module dlyrd_capture #(
  parameter int AW = 32,
  parameter int BW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] be_i,
  input  logic          wr_i,
  input  logic [CW-1:0] cmd_i,
  input  logic          burst_i,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] be_o,
  output logic          wr_o,
  output logic [CW-1:0] cmd_o,
  output logic          burst_o
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addr_o  <= '0;
      be_o    <= '0;
      wr_o    <= 1'b0;
      cmd_o   <= '0;
      burst_o <= 1'b0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      be_o    <= be_i;
      wr_o    <= wr_i;
      cmd_o   <= cmd_i;
      burst_o <= burst_i;
    end
  end
endmodule

// File: rtl/dlyrd_discard_timer.sv
module dlyrd_discard_timer #(
  parameter int TMR_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic active_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam logic [TMR_W-1:0] LAST = {TMR_W{1'b1}};

  logic [TMR_W-1:0] cnt_q;

  function automatic logic [TMR_W-1:0] tick(input logic [TMR_W-1:0] c);
    return c + {{(TMR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic at_end(input logic [TMR_W-1:0] c);
    return c == LAST;
  endfunction

  assign expire_o = active_i && !hold_i && at_end(cnt_q);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      cnt_q <= '0;
    else if (restart_i)
      cnt_q <= '0;
    else if (active_i && !hold_i && !at_end(cnt_q))
      cnt_q <= tick(cnt_q);
  end
endmodule

// File: rtl/dlyrd_ctrl.sv
module dlyrd_ctrl
  import dlyrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       cmp_stb_i,
  input  logic       cmp_err_i,
  input  logic       done_i,
  input  logic       expire_i,
  output dly_state_e state_o,
  output logic       accept_o,
  output logic       finish_o,
  output logic       clear_o,
  output logic       req_stb_o,
  output logic       cmp_err_o,
  output logic       flush_o
);
  dly_state_e st_q, st_d;
  logic       leave;

  assign accept_o = can_accept(st_q, req_i);
  assign finish_o = can_finish(st_q, cmp_stb_i);
  assign clear_o  = (st_q == ST_CMP) && done_i;
  assign leave    = clear_o || ((st_q == ST_CMP) && expire_i);
  assign state_o  = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_REQ;
      ST_REQ:  if (finish_o) st_d = ST_CMP;
      ST_CMP:  if (leave)    st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      req_stb_o <= 1'b0;
      flush_o   <= 1'b0;
      cmp_err_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      req_stb_o <= accept_o;
      flush_o   <= (st_q == ST_CMP) && expire_i && !done_i;
      if (finish_o)
        cmp_err_o <= cmp_err_i;
      else if (leave)
        cmp_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dlyrd_tracker.sv
module dlyrd_tracker
  import dlyrd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BW    = 4,
  parameter int CW    = 4,
  parameter int TMR_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_req_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [BW-1:0] tgt_be_i,
  input  logic          tgt_wr_i,
  input  logic [CW-1:0] tgt_cmd_i,
  input  logic          tgt_burst_i,
  input  logic          tgt_done_i,
  input  logic          tgt_busy_i,
  input  logic          mst_cmp_stb_i,
  input  logic          mst_cmp_err_i,
  output logic          mst_req_stb_o,
  output logic [AW-1:0] st_addr_o,
  output logic [BW-1:0] st_be_o,
  output logic          st_wr_o,
  output logic [CW-1:0] st_cmd_o,
  output logic          st_burst_o,
  output logic          req_pend_o,
  output logic          cmp_pend_o,
  output logic          cmp_err_o,
  output logic          cmp_flush_o
);
  dly_state_e state;
  logic       accept_evt;
  logic       finish_evt;
  logic       clear_evt;
  logic       expire_evt;

  dlyrd_capture #(.AW(AW), .BW(BW), .CW(CW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept_evt),
    .addr_i  (tgt_addr_i),
    .be_i    (tgt_be_i),
    .wr_i    (tgt_wr_i),
    .cmd_i   (tgt_cmd_i),
    .burst_i (tgt_burst_i),
    .addr_o  (st_addr_o),
    .be_o    (st_be_o),
    .wr_o    (st_wr_o),
    .cmd_o   (st_cmd_o),
    .burst_o (st_burst_o)
  );

  dlyrd_discard_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .restart_i (finish_evt),
    .active_i  (state == ST_CMP),
    .hold_i    (tgt_busy_i || tgt_done_i),
    .expire_o  (expire_evt)
  );

  dlyrd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_i     (tgt_req_i),
    .cmp_stb_i (mst_cmp_stb_i),
    .cmp_err_i (mst_cmp_err_i),
    .done_i    (tgt_done_i),
    .expire_i  (expire_evt),
    .state_o   (state),
    .accept_o  (accept_evt),
    .finish_o  (finish_evt),
    .clear_o   (clear_evt),
    .req_stb_o (mst_req_stb_o),
    .cmp_err_o (cmp_err_o),
    .flush_o   (cmp_flush_o)
  );

  assign req_pend_o = (state == ST_REQ);
  assign cmp_pend_o = (state == ST_CMP);
endmodule

// File: rtl/dlyrd_tracker_chk.sv
module dlyrd_tracker_chk #(
  parameter int AW    = 32,
  parameter int TMR_W = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tgt_req_i,
  input logic [AW-1:0] tgt_addr_i,
  input logic          tgt_done_i,
  input logic          tgt_busy_i,
  input logic          mst_cmp_stb_i,
  input logic          mst_req_stb_o,
  input logic [AW-1:0] st_addr_o,
  input logic          req_pend_o,
  input logic          cmp_pend_o,
  input logic          cmp_err_o,
  input logic          cmp_flush_o,
  input logic          accept_evt,
  input logic          clear_evt
);
  localparam logic [TMR_W:0] LIMIT = {1'b1, {TMR_W{1'b0}}};

  logic [TMR_W:0] seen_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      seen_q <= '0;
    else if (!cmp_pend_o)
      seen_q <= '0;
    else if (!tgt_busy_i && !tgt_done_i)
      seen_q <= seen_q + 1'b1;
  end

  always @(posedge clk) begin
    if (rst) begin
      p_reset_quiet_r1: assert (!req_pend_o && !cmp_pend_o && !mst_req_stb_o
                                && !cmp_flush_o && !cmp_err_o && st_addr_o == '0)
        else $error("reset state not clear");
    end
  end

  p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
    mst_req_stb_o |=> !mst_req_stb_o);

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> (st_addr_o == $past(tgt_addr_i)) && mst_req_stb_o);

  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (tgt_req_i && (req_pend_o || cmp_pend_o)) |=> $stable(st_addr_o) && !mst_req_stb_o);

  p_pend_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (req_pend_o && !mst_cmp_stb_i) |=> req_pend_o);

  p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(req_pend_o && cmp_pend_o));

  p_comp_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (req_pend_o && mst_cmp_stb_i) |=> cmp_pend_o);

  p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_pend_o && tgt_done_i) |=> !cmp_pend_o && !cmp_flush_o && !cmp_err_o);

  p_busy_no_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_pend_o && tgt_busy_i) |=> !cmp_flush_o);

  p_flush_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cmp_flush_o |=> !cmp_flush_o);

  p_flush_fall_r8: assert property (@(posedge clk) disable iff (rst)
    cmp_flush_o |-> !cmp_pend_o && $past(cmp_pend_o));

  p_flush_window_r9: assert property (@(posedge clk) disable iff (rst)
    cmp_flush_o |-> (seen_q == LIMIT));

  p_done_wins_r10: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> !cmp_flush_o);
endmodule

bind dlyrd_tracker dlyrd_tracker_chk #(.AW(AW), .TMR_W(TMR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tgt_req_i     (tgt_req_i),
  .tgt_addr_i    (tgt_addr_i),
  .tgt_done_i    (tgt_done_i),
  .tgt_busy_i    (tgt_busy_i),
  .mst_cmp_stb_i (mst_cmp_stb_i),
  .mst_req_stb_o (mst_req_stb_o),
  .st_addr_o     (st_addr_o),
  .req_pend_o    (req_pend_o),
  .cmp_pend_o    (cmp_pend_o),
  .cmp_err_o     (cmp_err_o),
  .cmp_flush_o   (cmp_flush_o),
  .accept_evt    (accept_evt),
  .clear_evt     (clear_evt)
);

// File: tb/test_dlyrd_tracker.sv
module test_dlyrd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 65536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tgt_req = 0, tgt_wr = 0, tgt_burst = 0, tgt_done = 0, tgt_busy = 0;
  logic [31:0] tgt_addr = '0;
  logic [3:0]  tgt_be = '0, tgt_cmd = '0;
  logic        cmp_stb = 0, cmp_err = 0;

  logic        req_stb, st_wr, st_burst, req_pend, cmp_pend, cmp_err_q, flush;
  logic [31:0] st_addr;
  logic [3:0]  st_be, st_cmd;

  int n_chk = 0;
  int n_fail = 0;

  dlyrd_tracker i_dlyrd_tracker (
    .clk(clk), .rst(rst),
    .tgt_req_i(tgt_req), .tgt_addr_i(tgt_addr), .tgt_be_i(tgt_be), .tgt_wr_i(tgt_wr),
    .tgt_cmd_i(tgt_cmd), .tgt_burst_i(tgt_burst), .tgt_done_i(tgt_done), .tgt_busy_i(tgt_busy),
    .mst_cmp_stb_i(cmp_stb), .mst_cmp_err_i(cmp_err), .mst_req_stb_o(req_stb),
    .st_addr_o(st_addr), .st_be_o(st_be), .st_wr_o(st_wr), .st_cmd_o(st_cmd),
    .st_burst_o(st_burst), .req_pend_o(req_pend), .cmp_pend_o(cmp_pend),
    .cmp_err_o(cmp_err_q), .cmp_flush_o(flush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: phase 0 idle, 1 waiting on master, 2 completion held
  int          m_phase = 0;
  int          m_wait  = 0;
  logic [31:0] m_addr  = '0;
  logic [3:0]  m_be = '0, m_cmd = '0;
  logic        m_wr = 0, m_burst = 0, m_stb = 0, m_flush = 0, m_err = 0;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_phase = 0; m_wait = 0; m_addr = '0; m_be = '0; m_cmd = '0;
      m_wr = 0; m_burst = 0; m_stb = 0; m_flush = 0; m_err = 0;
    end else begin
      m_stb = 0;
      m_flush = 0;
      if (m_phase == 0) begin
        if (tgt_req) begin
          m_addr = tgt_addr; m_be = tgt_be; m_wr = tgt_wr; m_cmd = tgt_cmd; m_burst = tgt_burst;
          m_stb = 1; m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (cmp_stb) begin
          m_phase = 2; m_err = cmp_err; m_wait = 0;
        end
      end else begin
        if (tgt_done) begin
          m_phase = 0; m_err = 0;
        end else if (!tgt_busy) begin
          m_wait++;
          if (m_wait == LIMIT) begin
            m_flush = 1; m_phase = 0; m_err = 0;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 addr", st_addr, m_addr);
      check("R2 be", st_be, m_be);
      check("R2 wr", st_wr, m_wr);
      check("R2 cmd", st_cmd, m_cmd);
      check("R2 burst", st_burst, m_burst);
      check("R3 strobe", req_stb, m_stb);
      check("R4 req_pend", req_pend, m_phase == 1);
      check("R5 cmp_pend", cmp_pend, m_phase == 2);
      check("R5 status", cmp_err_q, m_err);
      check("R8 flush", flush, m_flush);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input logic [31:0] a, input logic [3:0] b, input logic w,
                         input logic [3:0] c, input logic u);
    tgt_addr = a; tgt_be = b; tgt_wr = w; tgt_cmd = c; tgt_burst = u; tgt_req = 1;
    cyc(1);
    tgt_req = 0;
  endtask

  task automatic complete(input logic e);
    cmp_stb = 1; cmp_err = e;
    cyc(1);
    cmp_stb = 0; cmp_err = 0;
  endtask

  task automatic done_pulse;
    tgt_done = 1;
    cyc(1);
    tgt_done = 0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0;
    cyc(3);
    // R1: outputs cleared while reset held
    check("R1 req_pend", req_pend, 0);
    check("R1 cmp_pend", cmp_pend, 0);
    check("R1 addr", st_addr, 0);
    check("R1 flush", flush, 0);
    check("R1 strobe", req_stb, 0);
    rst = 0;
    cyc(2);

    // R2: accept, strobe once
    request(32'hA5A5_1000, 4'hF, 1'b0, 4'h6, 1'b1);
    check("R2 strobe", req_stb, 1);
    check("R2 addr", st_addr, 32'hA5A5_1000);
    cyc(1);
    check("R2 strobe single", req_stb, 0);
    // R3: second request while pending ignored
    request(32'h0000_BEEF, 4'h3, 1'b1, 4'h7, 1'b0);
    check("R3 addr kept", st_addr, 32'hA5A5_1000);
    check("R3 no strobe", req_stb, 0);
    // R6: done in REQ ignored
    done_pulse();
    check("R6 still pending", req_pend, 1);
    // R5: completion with error
    complete(1'b1);
    check("R5 cmp_pend", cmp_pend, 1);
    check("R5 status", cmp_err_q, 1);
    check("R4 req_pend low", req_pend, 0);
    request(32'h1111_2222, 4'h1, 1'b0, 4'hC, 1'b0);  // R3 ignored in COMP
    complete(1'b0);                                  // R5 ignored in COMP
    check("R5 status kept", cmp_err_q, 1);
    tgt_busy = 1; cyc(5); tgt_busy = 0;
    done_pulse();
    check("R6 idle", cmp_pend, 0);
    check("R6 status cleared", cmp_err_q, 0);
    complete(1'b1);                                  // R5 ignored in IDLE
    check("R5 idle ignore", cmp_pend, 0);
    done_pulse();                                    // R6 ignored in IDLE
    check("R6 idle ignore", req_pend, 0);

    // R9: partial wait, then a fresh entry must restart the timer
    request(32'h0000_4000, 4'h5, 1'b0, 4'hE, 1'b1);
    complete(1'b0);
    cyc(1000);
    done_pulse();
    request(32'h0000_8000, 4'hA, 1'b0, 4'h6, 1'b0);
    complete(1'b0);
    t0 = 0;
    cyc(100); t0 += 100;
    // R7: busy hold freezes the timer
    tgt_busy = 1; cyc(300); tgt_busy = 0;
    while (!flush && t0 < LIMIT + 10) begin cyc(1); t0++; end
    // entry on negedge after strobe edge; flush seen after LIMIT unheld edges
    check("R9 restart window", t0, LIMIT);
    check("R7 held flush", flush, 1);
    check("R8 cmp_pend dropped", cmp_pend, 0);
    cyc(1);
    check("R8 flush single", flush, 0);

    // R10: done on the expiry edge
    request(32'hFFFF_0004, 4'h8, 1'b1, 4'h2, 1'b1);
    complete(1'b1);
    while (m_wait < LIMIT - 1) cyc(1);
    done_pulse();
    check("R10 no flush", flush, 0);
    check("R10 idle", cmp_pend, 0);
    cyc(3);
    check("R10 no late flush", flush, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule